// File: doc/BRIEF.md
# RTC Interrupt and Wakeup Controller

This block sits next to a real-time clock counter chain and turns one of its periodic tick pulses into an interrupt. A cause-select field chooses which of the tick inputs matters. When that tick fires, a sticky status flag is set. The interrupt request line is the flag gated by an enable bit. Software clears the flag by writing one to it.

The same gated flag drives a wakeup pin that is meant to switch an external power regulator back on. The pin's active level can be programmed. A software bit can also force the pin active. Because the pin follows the latched flag rather than the tick itself, it holds its active level until software has serviced the interrupt and cleared the flag.

A plain write strobe with an address and a data byte reaches three registers. A read mux returns their contents with no delay. An active-low standby input isolates the registers from the bus while the system supply is going away. The enable, the flag and the polarity bit are deliberately left out of the system reset. Software must set them up after power-on. A soft-reset sequence puts the interrupt side back to a known state. The interface carries no data stream, so every pin is a plain control or status signal with no back-pressure.

Top module: `rtc_irq_wake`

## Requirements
- R1: After `rst_n` is released, the cause select reads 3'b001, and both the software-wake bit (CTRL bit 2) and the soft-reset bit (CTRL bit 3) read 0.
- R2: Register SEL (address 2, bits [2:0]) picks `tick_i[SEL]`. A pulse on the selected tick sets the flag (STAT, address 1, bit 0) at the next clock edge. Pulses on other ticks have no effect.
- R3: A write to STAT with bit 0 set clears the flag. A write to STAT with bit 0 clear leaves the flag unchanged.
- R4: If a selected tick and a write-one-to-clear arrive in the same cycle, the flag ends up set.
- R5: `irq_o` is high exactly when the flag is set and the enable bit (CTRL, address 0, bit 0) is 1.
- R6: Writing CTRL with bit 3 set and then writing CTRL with bit 3 clear is the soft reset. It clears the flag and the enable, whatever the second write's bit 0 holds, and it loads SEL with 3'b001.
- R7: With the polarity bit (CTRL bit 1) at 0, `wake_o` is active-high. With it at 1, `wake_o` is active-low.
- R8: The wakeup request is active while the flag and the enable are both set. It stays active for any number of cycles until the flag is cleared.
- R9: When the software-wake bit (CTRL bit 2) is set, the wakeup request is active regardless of the flag.
- R10: While `stby_n` is low, bus writes change no register: the enable, polarity, software-wake, SEL and flag keep their values, and a clear write is ignored.
- R11: Pulsing `rst_n` leaves the enable, the flag and the polarity bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| stby_n | input | 1 | Active-low standby; blocks register writes |
| tick_i | input | 8 | Single-cycle periodic tick pulses from the counter chain |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 CTRL, 1 STAT, 2 SEL) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, no delay |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup output, programmable polarity |

## Verification
The bench drives a clear-write and the selected tick in the same cycle. A design that let the clear win would lose an event and would report the flag as 0. It sends soft-reset sequences whose second write keeps the enable bit at 1. A design that only decoded the written data would leave the interrupt enabled and would keep a non-default SEL. It holds the flag for many idle cycles and pulses `rst_n` with the flag set. A wakeup pin wired to the raw tick would drop after one cycle, and a flag tied to the system reset would read 0. It also writes every register while in standby, where a missing write gate would show up in the read-back values.

// File: rtl/rtc_wk_pkg.sv
package rtc_wk_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_SEL  = 2'd2
  } reg_addr_e;

  // control register bit positions
  localparam int CTRL_EN   = 0;
  localparam int CTRL_POL  = 1;
  localparam int CTRL_SWW  = 2;
  localparam int CTRL_SRST = 3;
  localparam int CTRL_USED = 4;

  localparam int STAT_FLAG = 0;
endpackage

// File: rtl/rtc_wk_regs.sv
module rtc_wk_regs
  import rtc_wk_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] SEL_DEFAULT = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              flag_i,
  output logic              irq_en_o,
  output logic              pol_o,
  output logic              sww_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              srst_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_ok, ctrl_wr, sel_wr;
  logic srst_q;
  logic unused_wdata;

  assign wr_ok   = bus_wr & stby_n;
  assign ctrl_wr = wr_ok && (bus_addr == REG_CTRL);
  assign sel_wr  = wr_ok && (bus_addr == REG_SEL);
  assign clr_o   = wr_ok && (bus_addr == REG_STAT) && bus_wdata[STAT_FLAG];
  // soft reset fires on the write that takes the armed bit back to 0
  assign srst_o  = ctrl_wr && srst_q && !bus_wdata[CTRL_SRST];
  assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_USED];

  // enable and polarity live outside the system reset on purpose
  always_ff @(posedge clk) begin
    if (srst_o)       irq_en_o <= 1'b0;
    else if (ctrl_wr) irq_en_o <= bus_wdata[CTRL_EN];
  end

  always_ff @(posedge clk) begin
    if (ctrl_wr) pol_o <= bus_wdata[CTRL_POL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sww_o  <= 1'b0;
      srst_q <= 1'b0;
      sel_o  <= SEL_DEFAULT;
    end else begin
      if (ctrl_wr) begin
        sww_o  <= bus_wdata[CTRL_SWW];
        srst_q <= bus_wdata[CTRL_SRST];
      end
      if (srst_o)      sel_o <= SEL_DEFAULT;
      else if (sel_wr) sel_o <= bus_wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (bus_addr)
      REG_CTRL: begin
        rdata_o[CTRL_EN]   = irq_en_o;
        rdata_o[CTRL_POL]  = pol_o;
        rdata_o[CTRL_SWW]  = sww_o;
        rdata_o[CTRL_SRST] = srst_q;
      end
      REG_STAT: rdata_o[STAT_FLAG] = flag_i;
      REG_SEL:  rdata_o[SEL_W-1:0] = sel_o;
      default:  rdata_o = '0;
    endcase
  end

  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |=> (!irq_en_o && sel_o == SEL_DEFAULT)); // R6

  AST_STBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_n && !$isunknown({irq_en_o, pol_o}))
      |=> ($stable(irq_en_o) && $stable(pol_o) && $stable(sel_o) && $stable(sww_o))); // R10
endmodule

// File: rtl/rtc_wk_flag.sv
module rtc_wk_flag #(
  parameter int NUM_TICK = 8,
  parameter int SEL_W    = $clog2(NUM_TICK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TICK-1:0] tick_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                clr_i,
  input  logic                srst_i,
  output logic                flag_o
);
  logic [NUM_TICK-1:0] hit_vec;
  logic                hit;

  for (genvar i = 0; i < NUM_TICK; i++) begin : g_tap
    assign hit_vec[i] = tick_i[i] && (sel_i == SEL_W'(i));
  end
  assign hit = |hit_vec;

  // no system reset: the flag survives it; soft reset > event > clear
  always_ff @(posedge clk) begin
    if (srst_i)     flag_o <= 1'b0;
    else if (hit)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i[sel_i] && !srst_i) |=> flag_o); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !tick_i[sel_i] && !srst_i) |=> !flag_o); // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && tick_i[sel_i] && !srst_i) |=> flag_o); // R4

  AST_SRST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> !flag_o); // R6
endmodule

// File: rtl/rtc_wk_out.sv
module rtc_wk_out (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic en_i,
  input  logic sww_i,
  input  logic pol_i,
  output logic irq_o,
  output logic wake_o
);
  logic wake_req;

  assign irq_o    = flag_i & en_i;
  assign wake_req = irq_o | sww_i;
  assign wake_o   = pol_i ? ~wake_req : wake_req;

  AST_IRQ_WAKE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !$isunknown(pol_i)) |-> (wake_o == !pol_i)); // R7

  AST_SWW_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sww_i && !$isunknown(pol_i)) |-> (wake_o == !pol_i)); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |-> !irq_o); // R5
endmodule

// File: rtl/rtc_irq_wake.sv
module rtc_irq_wake
  import rtc_wk_pkg::*;
#(
  parameter int NUM_TICK = 8,
  parameter int SEL_W    = $clog2(NUM_TICK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stby_n,
  input  logic [NUM_TICK-1:0] tick_i,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o,
  output logic                wake_o
);
  localparam logic [SEL_W-1:0] SEL_DEF = SEL_W'(1);

  logic             flag, irq_en, pol, sww, srst, clr;
  logic [SEL_W-1:0] sel;

  rtc_wk_regs #(.SEL_W(SEL_W), .SEL_DEFAULT(SEL_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .flag_i(flag), .irq_en_o(irq_en), .pol_o(pol), .sww_o(sww),
    .sel_o(sel), .srst_o(srst), .clr_o(clr), .rdata_o(bus_rdata)
  );

  rtc_wk_flag #(.NUM_TICK(NUM_TICK), .SEL_W(SEL_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel_i(sel),
    .clr_i(clr), .srst_i(srst), .flag_o(flag)
  );

  rtc_wk_out u_out (
    .clk(clk), .rst_n(rst_n), .flag_i(flag), .en_i(irq_en),
    .sww_i(sww), .pol_i(pol), .irq_o(irq_o), .wake_o(wake_o)
  );

  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr && !srst && stby_n && !bus_wr) |=> irq_o); // R8
endmodule

// File: tb/sim_rtc_irq_wake.sv
module sim_rtc_irq_wake;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stby_n = 1'b1;
  logic [7:0] tick = '0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, wake;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_wake u0 (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .tick_i(tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq), .wake_o(wake)
  );

  // {wr, addr, wdata, tick, exp_flag, exp_irq, exp_wake}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h01, 8'h00, 3'b000}, // R5 enable on
    {1'b0, 2'd0, 8'h00, 8'h01, 3'b000}, // R2 unselected tick
    {1'b0, 2'd0, 8'h00, 8'h02, 3'b111}, // R2 selected tick sets
    {1'b1, 2'd1, 8'h00, 8'h00, 3'b111}, // R3 writing 0 keeps flag
    {1'b1, 2'd2, 8'h05, 8'h00, 3'b111}, // R2 select 5
    {1'b0, 2'd0, 8'h00, 8'h02, 3'b111}, // R2 old tick ignored
    {1'b1, 2'd1, 8'h01, 8'h00, 3'b000}, // R3 clear
    {1'b0, 2'd0, 8'h00, 8'h20, 3'b111}, // R2 tick 5 sets
    {1'b1, 2'd0, 8'h00, 8'h00, 3'b100}, // R5 enable off gates irq/wake
    {1'b1, 2'd0, 8'h03, 8'h00, 3'b110}, // R7 active-low asserted
    {1'b1, 2'd1, 8'h01, 8'h20, 3'b110}, // R4 set beats clear
    {1'b1, 2'd1, 8'h01, 8'h00, 3'b001}, // R7 active-low idle high
    {1'b1, 2'd0, 8'h07, 8'h00, 3'b000}, // R9 sw wake, active low
    {1'b1, 2'd0, 8'h05, 8'h00, 3'b001}, // R9 sw wake, active high
    {1'b1, 2'd0, 8'h01, 8'h00, 3'b000}  // R9 sw wake released
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_tick(input logic [7:0] t);
    @(negedge clk);
    tick = t;
    @(negedge clk);
    tick = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl sww/srst", d & 8'h0C, 8'h00);
    rd(2'd2, d); check("R1 sel default", d, 8'h01);

    // software init of the unreset bits
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    rd(2'd1, d); check("R3 init clear", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_wr = VEC[i][21]; bus_addr = VEC[i][20:19];
      bus_wdata = VEC[i][18:11]; tick = VEC[i][10:3];
      @(negedge clk);
      bus_wr = 1'b0; tick = '0; bus_addr = 2'd1;
      #1;
      check($sformatf("vec%0d flag (R2/R3/R4)", i), {7'd0, bus_rdata[0]}, {7'd0, VEC[i][2]});
      check($sformatf("vec%0d irq (R5)", i), {7'd0, irq}, {7'd0, VEC[i][1]});
      check($sformatf("vec%0d wake (R7/R8/R9)", i), {7'd0, wake}, {7'd0, VEC[i][0]});
    end

    // R8 hold until cleared (en=1, pol=0, sel=5)
    pulse_tick(8'h20);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check("R8 wake held", {7'd0, wake}, 8'h01);
    end
    wr(2'd1, 8'h01);
    #1 check("R8 wake released", {7'd0, wake}, 8'h00);

    // R6 soft reset
    pulse_tick(8'h20);
    wr(2'd0, 8'h09);
    #1 check("R6 armed, irq still up", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h01);
    #1 check("R6 irq removed", {7'd0, irq}, 8'h00);
    rd(2'd0, d); check("R6 enable cleared", d, 8'h00);
    rd(2'd1, d); check("R6 flag cleared", d, 8'h00);
    rd(2'd2, d); check("R6 sel default", d, 8'h01);

    // R10 standby blocks writes
    wr(2'd0, 8'h01);
    pulse_tick(8'h02);
    stby_n = 1'b0;
    wr(2'd0, 8'h06);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h07);
    rd(2'd0, d); check("R10 ctrl unchanged", d, 8'h01);
    rd(2'd1, d); check("R10 flag unchanged", d, 8'h01);
    rd(2'd2, d); check("R10 sel unchanged", d, 8'h01);
    check("R10 irq/wake", {6'd0, irq, wake}, 8'h03);
    stby_n = 1'b1;

    // R11 system reset spares enable, flag, polarity
    wr(2'd0, 8'h03);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(2'd0, d); check("R11 en/pol kept", d, 8'h03);
    rd(2'd1, d); check("R11 flag kept", d, 8'h01);
    check("R11 wake active-low", {7'd0, wake}, 8'h00);

    summary();
    $finish;
  end
endmodule